// File: doc/BRIEF.md
# Decode-Stage Operand Bypass and Load Interlock

This block steers register operands for a five-stage integer pipeline (fetch, decode, execute, memory, write-back) in which source operands are gathered in the decode stage. For each of the two source register numbers of the instruction in decode, it compares the number against the destination tags that travel with the instructions in execute and memory. It then drives a select code for that operand's bypass multiplexer and delivers the chosen 32-bit operand.

A 32-entry register file is part of the block. A write-back write becomes visible to a read of the same register in the same cycle, so no separate bypass path from write-back is needed.

When the instruction in execute is a load that produces a register the decode instruction needs, the value does not exist yet. The block raises a stall. The surrounding pipeline must then keep the program counter and the fetch/decode register unchanged and put a bubble, with its write-enable cleared, into execute. A configuration input turns this load interlock off. In that case nothing stalls, and the dependent instruction receives whatever older copy of the register is available.

Top module: `decode_bypass_ctrl`

## Requirements
- R1: After reset every register reads as zero when no bypass applies.
- R2: Register number 0 reads as zero, never selects a bypass and never causes a stall.
- R3: A write-back write (write-enable high, register non-zero) is returned by a read of the same register in the same cycle when no bypass applies.
- R4: A source that matches the execute destination, with execute write-enable high and execute not a load, gets select code 1 and receives the execute ALU result.
- R5: A source that matches the memory destination, with memory write-enable high and no usable execute match, gets select code 2 and receives the memory-stage value.
- R6: When execute and memory both match a source, the execute result wins (code 1).
- R7: A destination whose stage write-enable is low never matches and never stalls.
- R8: With the interlock enabled, a load in execute whose destination equals a non-zero source raises stall in that cycle. Stall means: hold the program counter and the fetch/decode register, and inject a bubble with write-enable cleared into execute.
- R9: With the interlock disabled, stall stays low. A source that matches a load in execute then takes the memory value if memory matches, and otherwise the register file value (code 0).
- R10: A value written to a non-zero register is returned by later reads until it is overwritten. A write to register 0 is dropped.
- R11: The two operands are resolved independently under the same rules. Select code 0 means register file, 1 means execute, 2 means memory, and 3 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the register file |
| interlock_en | input | 1 | Enables the load-use stall |
| id_src_a | input | 5 | First source register number in decode |
| id_src_b | input | 5 | Second source register number in decode |
| ex_dst | input | 5 | Destination tag of the execute instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| ex_alu_val | input | 32 | ALU result in execute |
| mem_dst | input | 5 | Destination tag of the memory instruction |
| mem_wen | input | 1 | Memory instruction writes a register |
| mem_val | input | 32 | Result carried in the memory stage |
| wb_dst | input | 5 | Write-back destination |
| wb_wen | input | 1 | Write-back write-enable |
| wb_val | input | 32 | Write-back data |
| sel_a | output | 2 | Bypass select, operand A (0 RF, 1 EX, 2 MEM) |
| sel_b | output | 2 | Bypass select, operand B |
| opnd_a | output | 32 | Operand A value |
| opnd_b | output | 32 | Operand B value |
| stall | output | 1 | Hold fetch/decode and bubble execute |

## Verification
The checker watches every cycle for the following. Register 0 must always read zero. Each nonzero select code must be backed by a real match with its write-enable and must deliver the matching bus. Execute must beat memory. Stall must appear for an enabled load match and must never appear when the interlock is off or the execute instruction is not a load. The checker also confirms that a write-through value, and a value written in the previous cycle, reach the operand. Other properties depend on history over many cycles, and only the bench scenarios can show them. These are the zero state after reset, values that stay in the register file across many cycles, a dropped write to register 0, and the stale operand a dependent instruction receives with the interlock off. The bench checks them against its own model of the register file.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_EX  = 2'd1,
    SRC_MEM = 2'd2
  } src_sel_e;

  // Priority: usable execute result first, then memory, then register file.
  function automatic src_sel_e pick_src(input logic ex_usable, input logic mem_hit);
    if (ex_usable)    return SRC_EX;
    else if (mem_hit) return SRC_MEM;
    else              return SRC_RF;
  endfunction

  // A tag comparison counts only for a live source and a writing producer.
  function automatic logic tag_hit(input logic [4:0] src, input logic [4:0] dst,
                                   input logic wen);
    return (src != 5'd0) && wen && (src == dst);
  endfunction

endpackage

// File: rtl/bp_regfile.sv
module bp_regfile #(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5,
  parameter int NRD    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NRD-1:0][REG_AW-1:0] rd_addr,
  output logic [NRD-1:0][XLEN-1:0]   rd_data,
  input  logic [REG_AW-1:0]          wr_addr,
  input  logic                       wr_en,
  input  logic [XLEN-1:0]            wr_data
);
  localparam int NREGS = 1 << REG_AW;

  logic [XLEN-1:0] store [NREGS];
  logic            wr_live;

  assign wr_live = wr_en && (wr_addr != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) store[i] <= '0;
    end else if (wr_live) begin
      store[wr_addr] <= wr_data;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (rd_addr[p] == '0)
        rd_data[p] = '0;
      else if (wr_live && (wr_addr == rd_addr[p]))
        rd_data[p] = wr_data;
      else
        rd_data[p] = store[rd_addr[p]];
    end
  end
endmodule

// File: rtl/bp_src_match.sv
module bp_src_match
  import bypass_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_wen,
  input  logic              ex_load,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wen,
  input  logic [XLEN-1:0]   rf_val,
  input  logic [XLEN-1:0]   ex_val,
  input  logic [XLEN-1:0]   mem_val,
  output src_sel_e          sel,
  output logic [XLEN-1:0]   opnd,
  output logic              load_hit
);
  logic ex_hit, mem_hit;

  assign ex_hit   = tag_hit(5'(src), 5'(ex_dst), ex_wen);
  assign mem_hit  = tag_hit(5'(src), 5'(mem_dst), mem_wen);
  assign load_hit = ex_hit && ex_load;
  assign sel      = pick_src(ex_hit && !ex_load, mem_hit);

  always_comb begin
    unique case (sel)
      SRC_EX:  opnd = ex_val;
      SRC_MEM: opnd = mem_val;
      default: opnd = rf_val;
    endcase
  end
endmodule

// File: rtl/bp_interlock.sv
module bp_interlock #(
  parameter int NSRC = 2
) (
  input  logic            enable,
  input  logic [NSRC-1:0] load_hit,
  output logic            stall
);
  assign stall = enable && (|load_hit);
endmodule

// File: rtl/decode_bypass_ctrl.sv
module decode_bypass_ctrl
  import bypass_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              interlock_en,
  input  logic [REG_AW-1:0] id_src_a,
  input  logic [REG_AW-1:0] id_src_b,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_wen,
  input  logic              ex_load,
  input  logic [XLEN-1:0]   ex_alu_val,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wen,
  input  logic [XLEN-1:0]   mem_val,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wen,
  input  logic [XLEN-1:0]   wb_val,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [XLEN-1:0]   opnd_a,
  output logic [XLEN-1:0]   opnd_b,
  output logic              stall
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][REG_AW-1:0] src_vec;
  logic [NSRC-1:0][XLEN-1:0]   rf_vec;
  logic [NSRC-1:0][XLEN-1:0]   opnd_vec;
  logic [NSRC-1:0][1:0]        sel_vec;
  logic [NSRC-1:0]             load_hit_vec;

  assign src_vec[0] = id_src_a;
  assign src_vec[1] = id_src_b;

  bp_regfile #(.XLEN(XLEN), .REG_AW(REG_AW), .NRD(NSRC)) rf_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (src_vec),
    .rd_data (rf_vec),
    .wr_addr (wb_dst),
    .wr_en   (wb_wen),
    .wr_data (wb_val)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    src_sel_e sel_s;
    bp_src_match #(.XLEN(XLEN), .REG_AW(REG_AW)) match_i (
      .src      (src_vec[s]),
      .ex_dst   (ex_dst),
      .ex_wen   (ex_wen),
      .ex_load  (ex_load),
      .mem_dst  (mem_dst),
      .mem_wen  (mem_wen),
      .rf_val   (rf_vec[s]),
      .ex_val   (ex_alu_val),
      .mem_val  (mem_val),
      .sel      (sel_s),
      .opnd     (opnd_vec[s]),
      .load_hit (load_hit_vec[s])
    );
    assign sel_vec[s] = sel_s;
  end

  bp_interlock #(.NSRC(NSRC)) ilk_i (
    .enable   (interlock_en),
    .load_hit (load_hit_vec),
    .stall    (stall)
  );

  assign sel_a  = sel_vec[0];
  assign sel_b  = sel_vec[1];
  assign opnd_a = opnd_vec[0];
  assign opnd_b = opnd_vec[1];
endmodule

// File: rtl/decode_bypass_chk.sv
module decode_bypass_chk #(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              interlock_en,
  input logic [REG_AW-1:0] id_src_a,
  input logic [REG_AW-1:0] id_src_b,
  input logic [REG_AW-1:0] ex_dst,
  input logic              ex_wen,
  input logic              ex_load,
  input logic [XLEN-1:0]   ex_alu_val,
  input logic [REG_AW-1:0] mem_dst,
  input logic              mem_wen,
  input logic [XLEN-1:0]   mem_val,
  input logic [REG_AW-1:0] wb_dst,
  input logic              wb_wen,
  input logic [XLEN-1:0]   wb_val,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic [XLEN-1:0]   opnd_a,
  input logic [XLEN-1:0]   opnd_b,
  input logic              stall,
  input logic [1:0]        load_hit_vec
);
  // R2
  zero_src_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_src_a == '0) |-> (sel_a == 2'd0 && opnd_a == '0 && !load_hit_vec[0]));
  // R2
  zero_src_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_src_b == '0) |-> (sel_b == 2'd0 && opnd_b == '0 && !load_hit_vec[1]));
  // R4
  ex_path_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == 2'd1) |-> (opnd_a == ex_alu_val && ex_wen && !ex_load && ex_dst == id_src_a));
  // R5
  mem_path_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_b == 2'd2) |-> (opnd_b == mem_val && mem_wen && mem_dst == id_src_b));
  // R6
  ex_wins_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_wen && !ex_load && id_src_a != '0 && ex_dst == id_src_a) |-> (sel_a == 2'd1));
  // R7
  no_wen_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_wen && !mem_wen) |-> (sel_a == 2'd0 && sel_b == 2'd0 && !stall));
  // R8
  load_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (interlock_en && ex_wen && ex_load && id_src_b != '0 && ex_dst == id_src_b) |-> stall);
  // R8
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (interlock_en && ex_wen && ex_load && $countones(load_hit_vec) != 0));
  // R9
  ilk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !interlock_en |-> !stall);
  // R11
  sel_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a != 2'd3) && (sel_b != 2'd3));
  // R3
  write_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_wen && wb_dst == id_src_a && id_src_a != '0 && sel_a == 2'd0) |-> (opnd_a == wb_val));
  // R10
  write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wb_wen) && $past(wb_dst) != '0 && id_src_a == $past(wb_dst)
     && sel_a == 2'd0 && !(wb_wen && wb_dst == id_src_a)) |-> (opnd_a == $past(wb_val)));
endmodule

bind decode_bypass_ctrl decode_bypass_chk #(.XLEN(XLEN), .REG_AW(REG_AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .interlock_en(interlock_en),
  .id_src_a(id_src_a), .id_src_b(id_src_b),
  .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load), .ex_alu_val(ex_alu_val),
  .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_val(mem_val),
  .wb_dst(wb_dst), .wb_wen(wb_wen), .wb_val(wb_val),
  .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b),
  .stall(stall), .load_hit_vec(load_hit_vec)
);

// File: tb/decode_bypass_ctrl_tb_top.sv
module decode_bypass_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        interlock_en = 1'b1;
  logic [4:0]  id_src_a = '0, id_src_b = '0, ex_dst = '0, mem_dst = '0, wb_dst = '0;
  logic        ex_wen = 1'b0, ex_load = 1'b0, mem_wen = 1'b0, wb_wen = 1'b0;
  logic [31:0] ex_alu_val = '0, mem_val = '0, wb_val = '0;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] opnd_a, opnd_b;
  logic        stall;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit done  = 0;
  logic [31:0] model_rf [32];

  always #4 clk = ~clk;

  decode_bypass_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .interlock_en(interlock_en),
    .id_src_a(id_src_a), .id_src_b(id_src_b),
    .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load), .ex_alu_val(ex_alu_val),
    .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_val(mem_val),
    .wb_dst(wb_dst), .wb_wen(wb_wen), .wb_val(wb_val),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b), .stall(stall)
  );

  // Expected select for one source, from the requirement text.
  function automatic int want_sel(input logic [4:0] r);
    int code = 0;
    if (r != 0) begin
      if (mem_wen && mem_dst == r) code = 2;
      if (ex_wen && !ex_load && ex_dst == r) code = 1;
    end
    return code;
  endfunction

  function automatic logic [31:0] want_val(input logic [4:0] r, input int code);
    if (code == 1) return ex_alu_val;
    if (code == 2) return mem_val;
    if (r == 0) return 32'd0;
    if (wb_wen && wb_dst == r) return wb_val;
    return model_rf[r];
  endfunction

  function automatic logic want_stall();
    logic ra, rb;
    ra = (id_src_a != 0) && (id_src_a == ex_dst);
    rb = (id_src_b != 0) && (id_src_b == ex_dst);
    return interlock_en && ex_wen && ex_load && (ra || rb);
  endfunction

  task automatic step(input string tag,
                      input logic [4:0] ra, input logic [4:0] rb,
                      input logic [4:0] ed, input logic ew, input logic el,
                      input logic [4:0] md, input logic mw,
                      input logic [4:0] wd, input logic ww, input logic [31:0] wv,
                      input logic ilk);
    int sa, sb;
    logic [31:0] va, vb;
    logic st;
    @(negedge clk);
    cyc++;
    id_src_a = ra; id_src_b = rb;
    ex_dst = ed; ex_wen = ew; ex_load = el; ex_alu_val = 32'hE000_0000 + cyc;
    mem_dst = md; mem_wen = mw; mem_val = 32'hA000_0000 + cyc;
    wb_dst = wd; wb_wen = ww; wb_val = wv; interlock_en = ilk;
    #2;
    sa = want_sel(ra); sb = want_sel(rb);
    va = want_val(ra, sa); vb = want_val(rb, sb);
    st = want_stall();
    tests++;
    if (int'(sel_a) != sa || int'(sel_b) != sb || opnd_a != va || opnd_b != vb || stall != st) begin
      fails++;
      $display("FAIL %s: sel_a=%0d/%0d sel_b=%0d/%0d opnd_a=%h/%h opnd_b=%h/%h stall=%0b/%0b (actual/expected)",
               tag, sel_a, sa, sel_b, sb, opnd_a, va, opnd_b, vb, stall, st);
    end
    if (ww && wd != 0) model_rf[wd] = wv;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model_rf[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: fresh registers read zero
    step("R1", 5'd5, 5'd31, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R1", 5'd1, 5'd17, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R3: same-cycle write-through, then R10 persistence
    step("R3", 5'd5, 5'd6, 0, 0, 0, 0, 0, 5'd5, 1, 32'h1111_0005, 1);
    step("R10", 5'd5, 5'd6, 0, 0, 0, 0, 0, 5'd6, 1, 32'h2222_0006, 1);
    step("R10", 5'd6, 5'd5, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R10: write to register 0 dropped; R2 reads zero
    step("R10", 5'd0, 5'd0, 0, 0, 0, 0, 0, 5'd0, 1, 32'hDEAD_BEEF, 1);
    step("R2", 5'd0, 5'd5, 5'd0, 1, 0, 5'd0, 1, 0, 0, 0, 1);
    step("R2", 5'd0, 5'd0, 5'd0, 1, 1, 5'd0, 1, 0, 0, 0, 1);
    // R4: execute match on A
    step("R4", 5'd5, 5'd6, 5'd5, 1, 0, 5'd9, 1, 0, 0, 0, 1);
    // R5 / R11: memory match on B only
    step("R5", 5'd5, 5'd6, 5'd7, 1, 0, 5'd6, 1, 0, 0, 0, 1);
    // R6: both stages match both sources
    step("R6", 5'd5, 5'd5, 5'd5, 1, 0, 5'd5, 1, 0, 0, 0, 1);
    // R7: write-enables low
    step("R7", 5'd5, 5'd6, 5'd5, 0, 0, 5'd6, 0, 0, 0, 0, 1);
    step("R7", 5'd5, 5'd6, 5'd5, 0, 1, 5'd6, 0, 0, 0, 0, 1);
    // R8: load-use on A and on B
    step("R8", 5'd5, 5'd6, 5'd5, 1, 1, 0, 0, 0, 0, 0, 1);
    step("R8", 5'd9, 5'd6, 5'd6, 1, 1, 5'd6, 1, 0, 0, 0, 1);
    // R9: interlock off, stale operand from RF or MEM
    step("R9", 5'd5, 5'd6, 5'd5, 1, 1, 0, 0, 0, 0, 0, 0);
    step("R9", 5'd5, 5'd6, 5'd5, 1, 1, 5'd5, 1, 0, 0, 0, 0);
    // R11: independent operands, mixed cases
    step("R11", 5'd6, 5'd5, 5'd6, 1, 0, 5'd5, 1, 5'd5, 1, 32'h3333_0005, 1);
    step("R11", 5'd6, 5'd5, 0, 0, 0, 0, 0, 0, 0, 0, 1);

    // Mixed traffic over a small register range to provoke matches
    for (int k = 0; k < 2000; k++) begin
      step("R11", 5'($urandom_range(0, 7)), 5'($urandom_range(0, 7)),
           5'($urandom_range(0, 7)), 1'($urandom), 1'($urandom),
           5'($urandom_range(0, 7)), 1'($urandom),
           5'($urandom_range(0, 7)), 1'($urandom), $urandom,
           1'($urandom_range(0, 3) != 0));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule